// File: doc/BRIEF.md
# Step-Attenuator Serial Write Sequencer

This block sits on the host side of a 6-bit digital step attenuator. It takes a requested attenuation, counted in 0.5 dB steps, through a valid/ready handshake. It then drives the three wires that load the attenuator: a serial clock, a data line and a latch strobe. The attenuator reads its code active-low, so the block sends the bitwise complement of the requested step count. Requests above the largest step count saturate first.

Every minimum time on the serial wires is set by a nanosecond constant. Each constant is turned into system-clock cycles by rounding up, using the `SYS_CLK_MHZ` parameter. This keeps the waveform legal at any system clock rate:

- The serial clock runs at no more than 10 MHz.
- Data changes only on falling clock edges.
- The strobe waits after the last rising edge before it goes high.
- The strobe stays high for a minimum width.
- The next request is held off until a long spacing between strobes has passed.

Top module: `atten_wr_seq`

## Requirements
- R1: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both high. From the next cycle on, `req_ready_o` is low and `busy_o` is high until the write, including its spacing wait, has finished. Requests presented in that time are ignored and do not change the code being sent.
- R2: The code sent is 63 minus the requested step count. Any request of 63 or more sends code 0. For example, 0 steps sends 63, 1 step sends 62 and 21 steps sends 42.
- R3: Each write sends exactly 6 bits, most significant bit first. Each bit is taken by the attenuator on a rising edge of `spi_clk_o`.
- R4: Each high phase and each low phase of `spi_clk_o` lasts at least 50 ns, so the serial clock never exceeds 10 MHz.
- R5: `spi_data_o` changes only while `spi_clk_o` is low. It is stable for at least 10 ns before each rising edge and does not change within 10 ns after it.
- R6: `spi_le_o` rises no sooner than 10 ns after the last rising edge of the word. `spi_clk_o` stays low for as long as `spi_le_o` is high.
- R7: Each high pulse on `spi_le_o` lasts at least 30 ns.
- R8: Consecutive rising edges of `spi_le_o` are at least 630 ns apart. `req_ready_o` returns high no sooner than 630 ns after `spi_le_o` falls.
- R9: `done_o` is a one-cycle pulse. It is high exactly in the cycle in which `spi_le_o` has just fallen.
- R10: While reset is low, `spi_clk_o`, `spi_data_o`, `spi_le_o`, `done_o` and `busy_o` are low and `req_ready_o` is high. A reset that arrives in the middle of a write returns the block to this idle state, and the next write is sent whole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_steps_i | input | STEP_W | Requested attenuation in 0.5 dB steps |
| req_ready_o | output | 1 | Block can accept a request |
| busy_o | output | 1 | A write or its spacing wait is in progress |
| done_o | output | 1 | One-cycle pulse when the latch strobe ends |
| spi_clk_o | output | 1 | Serial clock to the attenuator |
| spi_data_o | output | 1 | Serial data to the attenuator |
| spi_le_o | output | 1 | Latch strobe to the attenuator |

## Verification
The hardest case to reach from the ports is a request that arrives while a write is already in progress. A related hard case is a reset that cuts a word off partway through. Either one can leave a half-shifted code or a stale strobe behind.

The stimulus handles the first case by presenting a second, different step count right after each accepted request. The bench then confirms that the captured word still decodes to the first request. For the second case, the stimulus drops reset about forty cycles into a word, checks the idle levels, and sends a fresh write. That write must arrive as a whole 6-bit word.

A pin monitor runs alongside both cases. It times every clock phase, data change and strobe edge in system cycles against the nanosecond limits.

// File: rtl/atten_seq_pkg.sv
package atten_seq_pkg;

    // Minimum serial timing in nanoseconds
    localparam int T_HALF_NS = 50;
    localparam int T_LESU_NS = 10;
    localparam int T_LEPW_NS = 30;
    localparam int T_GAP_NS  = 630;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO,
        ST_HI,
        ST_SETUP,
        ST_PULSE,
        ST_GAP
    } seq_state_e;

    // Round a time up to whole system cycles, never below one
    function automatic int ns_to_cycles(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/atten_code_map.sv
module atten_code_map #(
    parameter int STEP_W    = 7,
    parameter int CODE_BITS = 6
) (
    input  logic [STEP_W-1:0]    steps_i,
    output logic [CODE_BITS-1:0] code_o
);
    localparam int MAX_STEPS = (1 << CODE_BITS) - 1;

    logic [CODE_BITS-1:0] sat_steps;

    always_comb begin
        if (steps_i > STEP_W'(MAX_STEPS)) begin
            sat_steps = CODE_BITS'(MAX_STEPS);
        end else begin
            sat_steps = steps_i[CODE_BITS-1:0];
        end
        // Active-low code: all ones minus the steps equals the complement
        code_o = ~sat_steps;
    end
endmodule

// File: rtl/atten_cycle_timer.sv
module atten_cycle_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expired_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i - W'(1);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: an expired count stays expired until reloaded (no wrap)
    a_r4_timer_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && expired_o) |=> expired_o);

endmodule

// File: rtl/atten_wr_seq.sv
module atten_wr_seq
    import atten_seq_pkg::*;
#(
    parameter int SYS_CLK_MHZ = 250,
    parameter int CODE_BITS   = 6,
    parameter int STEP_W      = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [STEP_W-1:0] req_steps_i,
    output logic              req_ready_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              spi_clk_o,
    output logic              spi_data_o,
    output logic              spi_le_o
);
    localparam int HALF_CYC = ns_to_cycles(T_HALF_NS, SYS_CLK_MHZ);
    localparam int LESU_CYC = ns_to_cycles(T_LESU_NS, SYS_CLK_MHZ);
    localparam int LEPW_CYC = ns_to_cycles(T_LEPW_NS, SYS_CLK_MHZ);
    localparam int GAP_CYC  = ns_to_cycles(T_GAP_NS, SYS_CLK_MHZ);
    localparam int TMR_W    = $clog2(GAP_CYC + 1);
    localparam int BIT_W    = $clog2(CODE_BITS);

    typedef struct packed {
        seq_state_e           st;
        logic [CODE_BITS-1:0] shreg;
        logic [BIT_W-1:0]     bitn;
        logic                 sclk;
        logic                 sdata;
        logic                 le;
        logic                 done;
    } seq_regs_t;

    seq_regs_t            r_d, r_q;
    logic [CODE_BITS-1:0] code;
    logic                 accept;
    logic                 tmr_load;
    logic [TMR_W-1:0]     tmr_len;
    logic                 tmr_expired;

    atten_code_map #(
        .STEP_W    (STEP_W),
        .CODE_BITS (CODE_BITS)
    ) code_map_i (
        .steps_i (req_steps_i),
        .code_o  (code)
    );

    atten_cycle_timer #(
        .W (TMR_W)
    ) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .len_i     (tmr_len),
        .expired_o (tmr_expired)
    );

    assign accept = req_valid_i && (r_q.st == ST_IDLE);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = TMR_W'(HALF_CYC);
        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st    = ST_LO;
                    r_d.shreg = code;
                    r_d.sdata = code[CODE_BITS-1];
                    r_d.bitn  = BIT_W'(CODE_BITS - 1);
                    tmr_load  = 1'b1;
                end
            end
            ST_LO: begin
                if (tmr_expired) begin
                    r_d.st   = ST_HI;
                    r_d.sclk = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            ST_HI: begin
                if (tmr_expired) begin
                    r_d.sclk = 1'b0;
                    tmr_load = 1'b1;
                    if (r_q.bitn == '0) begin
                        r_d.st    = ST_SETUP;
                        r_d.sdata = 1'b0;
                        tmr_len   = TMR_W'(LESU_CYC);
                    end else begin
                        r_d.st    = ST_LO;
                        r_d.bitn  = r_q.bitn - BIT_W'(1);
                        r_d.shreg = {r_q.shreg[CODE_BITS-2:0], 1'b0};
                        r_d.sdata = r_q.shreg[CODE_BITS-2];
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    r_d.st   = ST_PULSE;
                    r_d.le   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(LEPW_CYC);
                end
            end
            ST_PULSE: begin
                if (tmr_expired) begin
                    r_d.st   = ST_GAP;
                    r_d.le   = 1'b0;
                    r_d.done = 1'b1;
                    tmr_load = 1'b1;
                    tmr_len  = TMR_W'(GAP_CYC);
                end
            end
            ST_GAP: begin
                if (tmr_expired) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, shreg: '0, bitn: '0, sclk: 1'b0,
                     sdata: 1'b0, le: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready_o = (r_q.st == ST_IDLE);
    assign busy_o      = !req_ready_o;
    assign done_o      = r_q.done;
    assign spi_clk_o   = r_q.sclk;
    assign spi_data_o  = r_q.sdata;
    assign spi_le_o    = r_q.le;

    // R1: an accepted request closes the handshake on the next cycle
    a_r1_hold_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o) |=> (!req_ready_o && busy_o));

    // R5: data does not move while the serial clock stays high
    a_r5_data_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spi_clk_o && $past(spi_clk_o)) |-> $stable(spi_data_o));

    // R6: serial clock is low whenever the strobe is high
    a_r6_clk_low_le: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spi_le_o |-> !spi_clk_o);

    // R9: completion pulse marks the strobe's falling edge
    a_r9_done_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> $fell(spi_le_o));

    // R8: ready cannot return right after the strobe ends
    a_r8_gap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(spi_le_o) |=> !req_ready_o);

endmodule

// File: tb/atten_wr_seq_tb_top.sv
`timescale 1ns/1ps
module atten_wr_seq_tb_top;
    localparam int SYS_MHZ  = 250;
    localparam int HALF_MIN = (50 * SYS_MHZ + 999) / 1000;
    localparam int SU_MIN   = (10 * SYS_MHZ + 999) / 1000;
    localparam int PW_MIN   = (30 * SYS_MHZ + 999) / 1000;
    localparam int GAP_MIN  = (630 * SYS_MHZ + 999) / 1000;
    localparam int NVEC     = 8;
    // {steps[6:0], expected code[5:0]}
    localparam logic [12:0] VEC [0:NVEC-1] = '{
        {7'd0,   6'd63}, {7'd1,  6'd62}, {7'd63, 6'd0},  {7'd64, 6'd0},
        {7'd127, 6'd0},  {7'd21, 6'd42}, {7'd42, 6'd21}, {7'd32, 6'd31}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic [6:0] steps = '0;
    logic       ready, busy, done, sclk, sdata, le;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    atten_wr_seq #(.SYS_CLK_MHZ(SYS_MHZ), .CODE_BITS(6), .STEP_W(7)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_steps_i(steps),
        .req_ready_o(ready), .busy_o(busy), .done_o(done),
        .spi_clk_o(sclk), .spi_data_o(sdata), .spi_le_o(le)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", req, got, exp);
        end
    endtask

    // Pin monitor, sampled on falling system-clock edges
    int cyc = 0;
    int last_rise = -1000, last_fall = -1000, last_dchg = -1000;
    int le_rise = -1000, le_fall = -1000, prev_le_rise = -1000000;
    int nbits = 0, le_falls = 0, done_cnt = 0;
    bit gap_pending = 0;
    logic [5:0] capt = '0, latched = '0;
    int latched_n = 0;
    logic p_sclk = 0, p_sdata = 0, p_le = 0, p_ready = 1;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            nbits = 0; gap_pending = 0;
            last_rise = -1000; last_fall = -1000; last_dchg = -1000;
            prev_le_rise = -1000000;
        end else begin
            if (sclk && !p_sclk) begin
                chk(cyc - last_dchg >= SU_MIN, "R5 data setup", cyc - last_dchg, SU_MIN);
                chk(cyc - last_fall >= HALF_MIN, "R4 low phase", cyc - last_fall, HALF_MIN);
                capt = {capt[4:0], sdata};
                nbits++;
                last_rise = cyc;
            end
            if (!sclk && p_sclk) begin
                chk(cyc - last_rise >= HALF_MIN, "R4 high phase", cyc - last_rise, HALF_MIN);
                last_fall = cyc;
            end
            if (sdata != p_sdata) begin
                chk(!sclk, "R5 change while low", int'(sclk), 0);
                chk(cyc - last_rise >= SU_MIN, "R5 data hold", cyc - last_rise, SU_MIN);
                last_dchg = cyc;
            end
            if (le) chk(!sclk, "R6 clk low under LE", int'(sclk), 0);
            if (le && !p_le) begin
                chk(cyc - last_rise >= SU_MIN, "R6 LE setup", cyc - last_rise, SU_MIN);
                chk(cyc - prev_le_rise >= GAP_MIN, "R8 LE spacing", cyc - prev_le_rise, GAP_MIN);
                latched = capt; latched_n = nbits; nbits = 0;
                prev_le_rise = cyc; le_rise = cyc;
            end
            if (!le && p_le) begin
                chk(cyc - le_rise >= PW_MIN, "R7 LE width", cyc - le_rise, PW_MIN);
                chk(done === 1'b1, "R9 done at LE fall", int'(done), 1);
                le_fall = cyc; le_falls++; gap_pending = 1;
            end else if (done) begin
                chk(0, "R9 stray done", 1, 0);
            end
            if (done) done_cnt++;
            if (ready && !p_ready && gap_pending) begin
                chk(cyc - le_fall >= GAP_MIN, "R8 ready hold-off", cyc - le_fall, GAP_MIN);
                gap_pending = 0;
            end
        end
        p_sclk = sclk; p_sdata = sdata; p_le = le; p_ready = ready;
    end

    task automatic do_write(input logic [6:0] s, input logic [5:0] exp, input bit poke);
        int target;
        target = le_falls + 1;
        while (!ready) @(negedge clk);
        valid = 1'b1; steps = s;
        @(negedge clk);
        valid = 1'b0;
        chk(!ready && busy, "R1 closed after accept", int'(ready), 0);
        if (poke) begin
            // R1: request during busy must be ignored
            valid = 1'b1; steps = ~s;
            repeat (3) @(negedge clk);
            valid = 1'b0;
        end
        while (le_falls < target) @(negedge clk);
        chk(latched == exp, "R2 code value", int'(latched), int'(exp));
        chk(latched_n == 6, "R3 bit count", latched_n, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: idle levels in reset
        chk(!sclk && !sdata && !le && !done, "R10 reset pins", {sclk, sdata, le, done}, 0);
        chk(ready && !busy, "R10 reset ready", int'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][12:6], VEC[i][5:0], (i % 2) == 1);
        end
        chk(done_cnt == NVEC, "R9 done count", done_cnt, NVEC);
        // R10: reset in the middle of a word
        while (!ready) @(negedge clk);
        valid = 1'b1; steps = 7'd5;
        @(negedge clk);
        valid = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(!sclk && !sdata && !le, "R10 mid-write reset pins", {sclk, sdata, le}, 0);
        chk(ready && !busy, "R10 mid-write reset ready", int'(ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        do_write(7'd10, 6'd53, 1'b0);
        while (!ready) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got 0 exp 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule